// File: doc/BRIEF.md
# Dword Request/Response Mailbox Responder

This block is the device end of a dword-wide mailbox that a host drives through a small register port. The host pushes a request object one dword at a time into a write-mailbox register, then sets a start bit in the control register. The block checks that the request is well formed and holds a busy flag for a fixed processing time. It then raises a ready flag and offers the response object through a read-mailbox register. Each read of that register shows the current response dword. Writing zero to it acknowledges that dword and moves on to the next one.

The request buffer is also the response store. The built-in responder does no real payload processing. The response has the same length as the request. Its first two dwords echo the request header, and every payload dword is the bitwise inverse of the matching request dword. An abort bit in the control register empties the buffer and returns the mailbox to idle from any state.

Register map: word address 0 is control (bit 0 abort, bit 1 start); address 1 is status (bit 0 busy, bit 1 error, bit 2 ready); address 2 is the write mailbox; address 3 is the read mailbox. The control register and the write mailbox read back as zero.

Top module: `mbx_responder`

## Requirements
- R1: After reset the status register (address 1) reads zero: busy (bit 0), error (bit 1) and ready (bit 2) are clear, and the read mailbox (address 3) reads zero.
- R2: While the mailbox is idle with no error and the buffer is not full, each write to address 2 appends one dword to the request, in write order.
- R3: Writing 1 to control bit 1 (start) with a valid request sets busy in the cycle after the write. Busy holds for LATENCY cycles, then busy clears and ready sets.
- R4: Response dword 0 equals request dword 0, response dword 1 equals request dword 1, and response dword k (k >= 2) is the bitwise inverse of request dword k. The response has as many dwords as the request.
- R5: While ready is set, address 3 returns the current response dword. Writing zero there advances to the next dword. A nonzero write leaves the position unchanged.
- R6: Ready holds until the last response dword is acknowledged. Then ready clears and address 3 reads zero.
- R7: On start, the length in bits 17:0 of request dword 1 (counting both header dwords) must equal the number of dwords received, and at least two must have arrived. Otherwise error sets, and neither busy nor ready is raised.
- R8: A length field of zero stands for 2^18 dwords. With a buffer smaller than that, such a request sets error on start.
- R9: A write to address 2 when DEPTH dwords are already held sets error and is discarded.
- R10: A write to address 2 while busy or ready sets error.
- R11: Writing 1 to control bit 0 (abort) clears busy, error and ready and empties the buffer. Abort takes precedence over a start set in the same write.
- R12: A start written while error is set is ignored: busy stays clear and error stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |

## Verification
Writes take effect at the clock edge on which reg_we is high. Status and read-mailbox values follow from that edge with no further delay, because read data is combinational from the registered state. The bench therefore drives each write for one cycle starting at a falling edge, and samples status at the next falling edge.

After a start, busy is sampled at the first falling edge. It is sampled again LATENCY-1 falling edges later, where it must still be set. Ready is sampled one falling edge after that, when busy has just cleared. Each acknowledge is followed by a read of the next dword at the falling edge after its write. Error results are checked one cycle after the offending write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_READY = 2'd2
  } mbx_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_WMBX = 2'd2;
  localparam logic [1:0] ADDR_RMBX = 2'd3;

  localparam int CTRL_ABORT_BIT = 0;
  localparam int CTRL_GO_BIT    = 1;

  localparam int STAT_BUSY_BIT  = 0;
  localparam int STAT_ERR_BIT   = 1;
  localparam int STAT_READY_BIT = 2;

  localparam int LEN_W = 18;

  // Length field of header dword 1; an all-zero field means 2^LEN_W dwords.
  function automatic logic [LEN_W:0] decode_len(input logic [31:0] hdr);
    if (hdr[LEN_W-1:0] == '0) return {1'b1, {LEN_W{1'b0}}};
    return {1'b0, hdr[LEN_W-1:0]};
  endfunction

endpackage

// File: rtl/mbx_req_buffer.sv
module mbx_req_buffer #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          clear,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] rd_idx,
  output logic [DW-1:0] rd_word,
  output logic [DW-1:0] len_word,
  output logic [CW-1:0] count,
  output logic          full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][DW-1:0] mem;
  logic [CW-1:0]            count_q, count_d;
  logic                     count_en;

  // One storage word per slot, written when the fill pointer points at it.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DW-1:0] slot_q;
    logic          slot_en;
    assign slot_en = push && (count_q == CW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= wdata;
    end
    assign mem[g] = slot_q;
  end

  always_comb begin
    count_en = clear | push;
    count_d  = clear ? '0 : count_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign count    = count_q;
  assign full     = (count_q == CW'(DEPTH));
  assign rd_word  = mem[rd_idx[AW-1:0]];
  assign len_word = mem[1];

endmodule

// File: rtl/mbx_resp_fmt.sv
module mbx_resp_fmt #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          valid,
  input  logic [CW-1:0] idx,
  input  logic [DW-1:0] req_word,
  output logic [DW-1:0] resp_word
);

  // Header dwords pass through; payload dwords are returned inverted.
  always_comb begin
    if (!valid)              resp_word = '0;
    else if (idx < CW'(2))   resp_word = req_word;
    else                     resp_word = ~req_word;
  end

endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
  import mbx_pkg::*;
#(
  parameter int CW      = 4,
  parameter int LATENCY = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           abort,
  input  logic           wr_req,
  input  logic           ack,
  input  logic           full,
  input  logic [CW-1:0]  count,
  input  logic [LEN_W:0] len_dec,
  output logic           push,
  output logic           clear,
  output logic           busy,
  output logic           err,
  output logic           ready,
  output logic [CW-1:0]  rd_idx
);

  localparam int LW = $clog2(LATENCY + 1);

  mbx_state_e    state_q, state_d;
  logic          err_q, err_d;
  logic [CW-1:0] idx_q, idx_d;
  logic          idx_en;
  logic [LW-1:0] lat_q, lat_d;
  logic          lat_en;
  logic          len_ok, last;

  assign len_ok = (count >= CW'(2)) && (len_dec == (LEN_W+1)'(count));
  assign last   = (idx_q == count - CW'(1));
  assign push   = wr_req && !abort && (state_q == ST_IDLE) && !err_q && !full;

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    lat_d   = lat_q;
    lat_en  = 1'b0;
    clear   = 1'b0;
    if (abort) begin
      state_d = ST_IDLE;
      err_d   = 1'b0;
      clear   = 1'b1;
      idx_en  = 1'b1;
      idx_d   = '0;
    end else begin
      if (wr_req && ((state_q != ST_IDLE) || full)) err_d = 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          if (go && !err_q) begin
            if (len_ok) begin
              state_d = ST_BUSY;
              lat_en  = 1'b1;
              lat_d   = LW'(LATENCY - 1);
            end else begin
              err_d = 1'b1;
            end
          end
        end
        ST_BUSY: begin
          if (lat_q == '0) begin
            state_d = ST_READY;
            idx_en  = 1'b1;
            idx_d   = '0;
          end else begin
            lat_en = 1'b1;
            lat_d  = lat_q - LW'(1);
          end
        end
        ST_READY: begin
          if (ack) begin
            idx_en = 1'b1;
            if (last) begin
              state_d = ST_IDLE;
              clear   = 1'b1;
              idx_d   = '0;
            end else begin
              idx_d = idx_q + CW'(1);
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      idx_q   <= '0;
      lat_q   <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (idx_en) idx_q <= idx_d;
      if (lat_en) lat_q <= lat_d;
    end
  end

  assign busy   = (state_q == ST_BUSY);
  assign ready  = (state_q == ST_READY);
  assign err    = err_q;
  assign rd_idx = idx_q;

  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !err && !ready));

  assert_ready_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ack && !abort) |=> ready);

  assert_idx_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ack && !abort) |=> $stable(rd_idx));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full && !abort) |=> err);

  assert_busy_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && (busy || ready) && !abort) |=> err);

  assert_bad_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !abort && !busy && !ready && !err && !len_ok) |=> (err && !busy));

  assert_go_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !abort && err && !busy) |=> !busy);

endmodule

// File: rtl/mbx_responder.sv
module mbx_responder
  import mbx_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int LATENCY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);

  localparam int DW = 32;
  localparam int CW = $clog2(DEPTH + 1);

  logic          ctrl_wr, go, abort, wr_req, ack;
  logic          push, clear, full, busy, err, ready;
  logic [CW-1:0] count, rd_idx;
  logic [DW-1:0] req_word, len_word, resp_word;
  logic [LEN_W:0] len_dec;

  assign ctrl_wr = reg_we && (reg_addr == ADDR_CTRL);
  assign go      = ctrl_wr && reg_wdata[CTRL_GO_BIT];
  assign abort   = ctrl_wr && reg_wdata[CTRL_ABORT_BIT];
  assign wr_req  = reg_we && (reg_addr == ADDR_WMBX);
  assign ack     = reg_we && (reg_addr == ADDR_RMBX) && (reg_wdata == '0);
  assign len_dec = decode_len(len_word);

  mbx_req_buffer #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .clear    (clear),
    .wdata    (reg_wdata),
    .rd_idx   (rd_idx),
    .rd_word  (req_word),
    .len_word (len_word),
    .count    (count),
    .full     (full)
  );

  mbx_engine #(.CW(CW), .LATENCY(LATENCY)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .abort   (abort),
    .wr_req  (wr_req),
    .ack     (ack),
    .full    (full),
    .count   (count),
    .len_dec (len_dec),
    .push    (push),
    .clear   (clear),
    .busy    (busy),
    .err     (err),
    .ready   (ready),
    .rd_idx  (rd_idx)
  );

  mbx_resp_fmt #(.DW(DW), .CW(CW)) u_fmt (
    .valid     (ready),
    .idx       (rd_idx),
    .req_word  (req_word),
    .resp_word (resp_word)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_STAT: begin
        reg_rdata[STAT_BUSY_BIT]  = busy;
        reg_rdata[STAT_ERR_BIT]   = err;
        reg_rdata[STAT_READY_BIT] = ready;
      end
      ADDR_RMBX: reg_rdata = resp_word;
      default:   reg_rdata = '0;
    endcase
  end

  assert_rmbx_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && (reg_addr == ADDR_RMBX)) |-> (reg_rdata == '0));

  assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ready));

endmodule

// File: tb/tb_mbx_responder.sv
module tb_mbx_responder;

  localparam int DEPTH   = 8;
  localparam int LATENCY = 4;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int n_chk;
  int n_err;

  mbx_responder #(.DEPTH(DEPTH), .LATENCY(LATENCY)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [3:0]  n;
    logic [17:0] lenf;
    logic [31:0] seed;
    logic        exp_err;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{n: 4'd2, lenf: 18'd2, seed: 32'hA000_0001, exp_err: 1'b0},
    '{n: 4'd5, lenf: 18'd5, seed: 32'h1234_5600, exp_err: 1'b0},
    '{n: 4'd8, lenf: 18'd8, seed: 32'h0F0F_0000, exp_err: 1'b0},
    '{n: 4'd4, lenf: 18'd6, seed: 32'h5555_0000, exp_err: 1'b1},
    '{n: 4'd3, lenf: 18'd0, seed: 32'h7777_0000, exp_err: 1'b1},
    '{n: 4'd1, lenf: 18'd1, seed: 32'h3333_0000, exp_err: 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] req_dw(input vec_t v, input int i);
    if (i == 0) return v.seed;
    if (i == 1) return {14'd0, v.lenf};
    return v.seed + 32'(i);
  endfunction

  function automatic logic [31:0] resp_dw(input vec_t v, input int i);
    if (i < 2) return req_dw(v, i);
    return ~req_dw(v, i);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    n_chk     = 0;
    n_err     = 0;
    rst_n     = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = 2'd0;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, v); chk("R1 status after reset", v, 32'h0);
    rd(2'd3, v); chk("R1 read mailbox after reset", v, 32'h0);

    // Vector table: R2 R3 R4 R5 R6 R7 R8
    for (int k = 0; k < NV; k++) begin
      wr(2'd0, 32'h1);
      for (int i = 0; i < int'(VECS[k].n); i++) wr(2'd2, req_dw(VECS[k], i));
      wr(2'd0, 32'h2);
      if (VECS[k].exp_err) begin
        rd(2'd1, v); chk("R7 R8 bad length sets error only", v, 32'h2);
        @(negedge clk);
        rd(2'd1, v); chk("R7 no busy or ready after bad length", v, 32'h2);
      end else begin
        rd(2'd1, v); chk("R3 busy after start", v, 32'h1);
        repeat (LATENCY - 1) @(negedge clk);
        rd(2'd1, v); chk("R3 busy held for latency", v, 32'h1);
        @(negedge clk);
        rd(2'd1, v); chk("R3 ready after latency", v, 32'h4);
        for (int i = 0; i < int'(VECS[k].n); i++) begin
          rd(2'd3, v); chk("R2 R4 response dword", v, resp_dw(VECS[k], i));
          if (i == 1) begin
            wr(2'd3, 32'h1);
            rd(2'd3, v); chk("R5 nonzero write does not advance", v, resp_dw(VECS[k], i));
          end
          if (i == int'(VECS[k].n) - 1) begin
            rd(2'd1, v); chk("R6 ready before final ack", v, 32'h4);
          end
          wr(2'd3, 32'h0);
        end
        rd(2'd1, v); chk("R6 ready clear after final ack", v, 32'h0);
        rd(2'd3, v); chk("R6 read mailbox zero when idle", v, 32'h0);
      end
    end

    // R9 overflow
    wr(2'd0, 32'h1);
    for (int i = 0; i < DEPTH; i++) wr(2'd2, (i == 1) ? 32'(DEPTH) : 32'hC0DE_0000 + 32'(i));
    rd(2'd1, v); chk("R9 full buffer no error", v, 32'h0);
    wr(2'd2, 32'hDEAD_BEEF);
    rd(2'd1, v); chk("R9 overflow sets error", v, 32'h2);

    // R12 start ignored while error set
    wr(2'd0, 32'h2);
    rd(2'd1, v); chk("R12 start ignored under error", v, 32'h2);
    @(negedge clk);
    rd(2'd1, v); chk("R12 still no busy", v, 32'h2);

    // R11 abort clears error
    wr(2'd0, 32'h1);
    rd(2'd1, v); chk("R11 abort clears error", v, 32'h0);

    // R10 write while busy, then abort from ready
    wr(2'd2, 32'h0000_0101);
    wr(2'd2, 32'h0000_0002);
    wr(2'd0, 32'h2);
    wr(2'd2, 32'h1111_1111);
    rd(2'd1, v); chk("R10 write while busy sets error", v, 32'h3);
    repeat (LATENCY) @(negedge clk);
    rd(2'd1, v); chk("R10 ready with error kept", v, 32'h6);
    rd(2'd3, v); chk("R10 discarded write left response intact", v, 32'h0000_0101);
    wr(2'd2, 32'h2222_2222);
    rd(2'd1, v); chk("R10 write while ready sets error", v, 32'h6);
    wr(2'd0, 32'h1);
    rd(2'd1, v); chk("R11 abort clears ready and error", v, 32'h0);
    rd(2'd3, v); chk("R11 read mailbox zero after abort", v, 32'h0);

    // R11 abort wins over start in the same write
    wr(2'd2, 32'h0000_0202);
    wr(2'd2, 32'h0000_0002);
    wr(2'd0, 32'h3);
    rd(2'd1, v); chk("R11 abort beats start", v, 32'h0);
    wr(2'd0, 32'h2);
    rd(2'd1, v); chk("R11 buffer emptied so start errors", v, 32'h2);
    wr(2'd0, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule